// File: doc/BRIEF.md
# Set-Associative Cache Tag and State Controller

This block keeps the tags, line state and line data of a set-associative cache whose set count, line length and associativity are parameters. A requester presents one word read or write per cycle. In the same cycle the block answers with a status code and, on a read hit, the word. A read miss sends a line request to the next level. The block tracks one outstanding line at a time, and the returning line is written in when the fill response arrives.

Three parameter codes select the behaviour. The replacement code picks least-recently-used or first-in-first-out victims. The write code picks read-only, write-back or write-through. The allocation code picks whether the victim way is claimed when the miss happens or only when the fill data comes back. Write-back evictions of modified lines leave through a full-line writeback port. Written words that the cache forwards leave through a single-word port. If the set count or the way count is zero, the cache is absent and every request passes straight through to the next level.

Top module: `cache_tagctl`

## Requirements
- R1: The block holds NSETS*WAYS lines of LINE_WORDS words each. A word address splits into a word offset (low log2(LINE_WORDS) bits), a set index (next log2(NSETS) bits) and a tag (remaining bits). NSETS and LINE_WORDS are powers of two, both at least 2.
- R2: rsp_status codes are 0 = hit, 1 = miss, 2 = miss on the line already being fetched, 3 = reservation fail. A read hit returns the addressed word on rsp_rdata in the same cycle.
- R3: A read miss while no fill is outstanding returns 1 and raises fill_req_valid with the line address (offset bits zero). Only one fill is outstanding at a time. A read of that line returns 2 and sends no request. A read miss to any other line returns 3.
- R4: With allocation at miss (ALLOC_ON_FILL=0), the victim way is invalidated in the miss cycle, so its old line stops hitting at once. The fill is then written into that reserved way.
- R5: With allocation at fill (ALLOC_ON_FILL=1), the victim is chosen in the fill cycle. The old line keeps hitting until the fill arrives.
- R6: The victim is the lowest-numbered invalid way. If every way is valid, it is the oldest way. Under REPL=0 (LRU), age is refreshed by hits and installs. Under REPL=1 (FIFO), age is refreshed by installs only.
- R7: Under WPOL=1 (write-back), a write hit updates the word, marks the line modified and forwards nothing. Evicting a modified victim raises wb_valid with the victim's line address and full line data. This happens in the miss cycle under allocation at miss, and in the fill cycle under allocation at fill.
- R8: Under WPOL=2 (write-through), a write hit updates the word and also forwards it on fwd_*. wb_valid never rises.
- R9: A write that misses, on a writable cache, returns 1, is forwarded on fwd_* and allocates nothing. A write to the line being fetched returns 3 and is not forwarded.
- R10: Under WPOL=0 (read-only), every write returns 3 and raises ro_err. It changes no cache state and sends nothing.
- R11: A request in a cycle with fill_rsp_valid high returns 3 and has no effect. The fill is written in.
- R12: With NSETS*WAYS = 0, every request returns 1. Reads raise fill_req_valid with the request address, writes are forwarded, and fill responses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write word |
| rsp_status | output | 2 | Response code for the current request |
| rsp_rdata | output | DW | Read word on hit |
| ro_err | output | 1 | Write attempted on read-only cache |
| fill_req_valid | output | 1 | Line request to next level |
| fill_req_addr | output | AW | Line address of that request |
| fill_rsp_valid | input | 1 | Fill data returning |
| fill_rsp_data | input | DW*LINE_WORDS | Full line of fill data, word 0 in low bits |
| wb_valid | output | 1 | Modified line evicted |
| wb_addr | output | AW | Line address of evicted line |
| wb_data | output | DW*LINE_WORDS | Evicted line data |
| fwd_valid | output | 1 | Word write forwarded to next level |
| fwd_addr | output | AW | Address of forwarded write |
| fwd_data | output | DW | Forwarded word |

## Verification
Four instances are driven separately: write-back LRU with allocation at miss, write-through FIFO with allocation at fill, read-only, and the zero-line bypass. Hit, miss and re-miss sequences within one set separate LRU from FIFO victim choice. A lookup of the victim line while its replacement is outstanding separates the two allocation timings. A modified line is evicted to confirm the writeback address and merged data, and the same eviction under write-through confirms that nothing is written back. Writes that miss or target the line being fetched, and requests that collide with a fill, check that the refusal paths leave state untouched.

// File: rtl/cache_tagctl.sv
module cache_tagctl #(
  parameter int AW            = 16,
  parameter int DW            = 32,
  parameter int NSETS         = 4,
  parameter int WAYS          = 2,
  parameter int LINE_WORDS    = 4,
  parameter int REPL          = 0,
  parameter int WPOL          = 1,
  parameter bit ALLOC_ON_FILL = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [AW-1:0]            req_addr,
  input  logic [DW-1:0]            req_wdata,
  output logic [1:0]               rsp_status,
  output logic [DW-1:0]            rsp_rdata,
  output logic                     ro_err,
  output logic                     fill_req_valid,
  output logic [AW-1:0]            fill_req_addr,
  input  logic                     fill_rsp_valid,
  input  logic [DW*LINE_WORDS-1:0] fill_rsp_data,
  output logic                     wb_valid,
  output logic [AW-1:0]            wb_addr,
  output logic [DW*LINE_WORDS-1:0] wb_data,
  output logic                     fwd_valid,
  output logic [AW-1:0]            fwd_addr,
  output logic [DW-1:0]            fwd_data
);
  localparam int NLINES = NSETS * WAYS;
  localparam int LB     = DW * LINE_WORDS;
  localparam int OFFW   = $clog2(LINE_WORDS);
  localparam int WW     = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [1:0] ST_HIT = 2'd0, ST_MISS = 2'd1, ST_PEND = 2'd2, ST_FAIL = 2'd3;

  if (NLINES == 0) begin : g_bypass
    assign rsp_status     = req_valid ? ST_MISS : ST_HIT;
    assign rsp_rdata      = '0;
    assign ro_err         = 1'b0;
    assign fill_req_valid = req_valid && !req_write;
    assign fill_req_addr  = req_addr;
    assign wb_valid       = 1'b0;
    assign wb_addr        = '0;
    assign wb_data        = '0;
    assign fwd_valid      = req_valid && req_write;
    assign fwd_addr       = req_addr;
    assign fwd_data       = req_wdata;

    AST_BYP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (rsp_status == ST_MISS && !wb_valid)); // R12
  end else begin : g_cache
    localparam int IDXW = $clog2(NSETS);
    localparam int TAGW = AW - OFFW - IDXW;

    logic [TAGW-1:0] tag_q   [NSETS][WAYS];
    logic [LB-1:0]   data_q  [NSETS][WAYS];
    logic [WW-1:0]   age_q   [NSETS][WAYS];
    logic [WAYS-1:0] valid_q [NSETS];
    logic [WAYS-1:0] dirty_q [NSETS];
    logic            pend_q;
    logic [AW-OFFW-1:0] pend_line_q;
    logic [WW-1:0]   pend_way_q;

    function automatic logic [WW-1:0] pick(input logic [IDXW-1:0] s);
      logic found;
      logic [WW-1:0] v;
      found = 1'b0;
      v = '0;
      for (int w = 0; w < WAYS; w++)
        if (!found && !valid_q[s][w]) begin found = 1'b1; v = WW'(w); end
      if (!found)
        for (int w = 0; w < WAYS; w++)
          if (age_q[s][w] == WW'(WAYS-1)) v = WW'(w);
      return v;
    endfunction

    wire [AW-OFFW-1:0] line_r = req_addr[AW-1:OFFW];
    wire [IDXW-1:0]    ridx   = req_addr[OFFW +: IDXW];
    wire [TAGW-1:0]    rtag   = req_addr[AW-1 -: TAGW];
    wire [OFFW-1:0]    roff   = req_addr[OFFW-1:0];
    wire [IDXW-1:0]    pidx   = pend_line_q[IDXW-1:0];
    wire [TAGW-1:0]    ptag   = pend_line_q[AW-OFFW-1 -: TAGW];

    logic [WAYS-1:0] hit_vec;
    logic            hit;
    logic [WW-1:0]   hway;
    always_comb begin
      hit_vec = '0;
      hway = '0;
      for (int w = 0; w < WAYS; w++)
        if (valid_q[ridx][w] && tag_q[ridx][w] == rtag) begin
          hit_vec[w] = 1'b1;
          hway = WW'(w);
        end
      hit = |hit_vec;
    end

    wire [WW-1:0] vic_r    = pick(ridx);
    wire [WW-1:0] vic_f    = pick(pidx);
    wire [WW-1:0] inst_way = ALLOC_ON_FILL ? vic_f : pend_way_q;
    wire pmatch  = pend_q && (pend_line_q == line_r);
    wire act     = req_valid && !fill_rsp_valid;
    wire install = fill_rsp_valid && pend_q;
    wire ro_w    = act && req_write && (WPOL == 0);
    wire wr_hit  = act && req_write && (WPOL != 0) && hit;
    wire wr_miss = act && req_write && (WPOL != 0) && !hit && !pmatch;
    wire rd_hit  = act && !req_write && hit;
    wire rd_new  = act && !req_write && !hit && !pend_q;
    wire ev_miss = rd_new && !ALLOC_ON_FILL && valid_q[ridx][vic_r] && dirty_q[ridx][vic_r];
    wire ev_fill = install && ALLOC_ON_FILL && valid_q[pidx][vic_f] && dirty_q[pidx][vic_f];

    always_comb begin
      if (!req_valid)          rsp_status = ST_HIT;
      else if (fill_rsp_valid) rsp_status = ST_FAIL;
      else if (req_write)      rsp_status = (WPOL == 0) ? ST_FAIL : hit ? ST_HIT : pmatch ? ST_FAIL : ST_MISS;
      else                     rsp_status = hit ? ST_HIT : pmatch ? ST_PEND : pend_q ? ST_FAIL : ST_MISS;
    end

    assign rsp_rdata      = rd_hit ? data_q[ridx][hway][int'(roff)*DW +: DW] : '0;
    assign ro_err         = ro_w;
    assign fill_req_valid = rd_new;
    assign fill_req_addr  = {line_r, {OFFW{1'b0}}};
    assign wb_valid       = ev_miss || ev_fill;
    assign wb_addr        = ev_miss ? {tag_q[ridx][vic_r], ridx, {OFFW{1'b0}}}
                                    : {tag_q[pidx][vic_f], pidx, {OFFW{1'b0}}};
    assign wb_data        = ev_miss ? data_q[ridx][vic_r] : data_q[pidx][vic_f];
    assign fwd_valid      = (wr_hit && WPOL == 2) || wr_miss;
    assign fwd_addr       = req_addr;
    assign fwd_data       = req_wdata;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q      <= 1'b0;
        pend_line_q <= '0;
        pend_way_q  <= '0;
        for (int s = 0; s < NSETS; s++) begin
          valid_q[s] <= '0;
          dirty_q[s] <= '0;
          for (int w = 0; w < WAYS; w++) age_q[s][w] <= WW'(w);
        end
      end else if (install) begin
        valid_q[pidx][inst_way] <= 1'b1;
        dirty_q[pidx][inst_way] <= 1'b0;
        pend_q <= 1'b0;
        for (int w = 0; w < WAYS; w++)
          if (WW'(w) == inst_way) age_q[pidx][w] <= '0;
          else if (age_q[pidx][w] < age_q[pidx][inst_way]) age_q[pidx][w] <= age_q[pidx][w] + 1'b1;
      end else begin
        if (wr_hit && WPOL == 1) dirty_q[ridx][hway] <= 1'b1;
        if ((wr_hit || rd_hit) && REPL == 0)
          for (int w = 0; w < WAYS; w++)
            if (WW'(w) == hway) age_q[ridx][w] <= '0;
            else if (age_q[ridx][w] < age_q[ridx][hway]) age_q[ridx][w] <= age_q[ridx][w] + 1'b1;
        if (rd_new) begin
          pend_q      <= 1'b1;
          pend_line_q <= line_r;
          pend_way_q  <= vic_r;
          if (!ALLOC_ON_FILL) begin
            valid_q[ridx][vic_r] <= 1'b0;
            dirty_q[ridx][vic_r] <= 1'b0;
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (install) begin
        tag_q[pidx][inst_way]  <= ptag;
        data_q[pidx][inst_way] <= fill_rsp_data;
      end else if (wr_hit) begin
        data_q[ridx][hway][int'(roff)*DW +: DW] <= req_wdata;
      end
    end

    AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R2
    AST_FILL_TRACKED: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req_valid |=> pend_q); // R3
    AST_FILL_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_rsp_valid && pend_q) |=> !pend_q); // R5
    AST_WB_ONLY_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (WPOL == 1)); // R8
    AST_RO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ro_err |-> (!fwd_valid && !fill_req_valid && !wb_valid)); // R10
    AST_FILL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      fill_rsp_valid |-> (!fill_req_valid && !fwd_valid)); // R11
  end
endmodule

// File: tb/tb_cache_tagctl.sv
module tb_cache_tagctl;
  localparam int AW = 16, DW = 32, LW = 4, LB = DW * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0] rv = '0, fv = '0;
  logic rw = 1'b0;
  logic [AW-1:0] ra = '0;
  logic [DW-1:0] rwd = '0;
  logic [LB-1:0] fd = '0;

  logic [1:0]    st  [4];
  logic [DW-1:0] rd  [4];
  logic          roe [4], frv [4], wbv [4], fwv [4];
  logic [AW-1:0] fra [4], wba [4], fwa [4];
  logic [LB-1:0] wbd [4];
  logic [DW-1:0] fwd [4];

  int checks = 0, fails = 0;

  cache_tagctl #(.REPL(0), .WPOL(1), .ALLOC_ON_FILL(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_write(rw), .req_addr(ra), .req_wdata(rwd),
    .rsp_status(st[0]), .rsp_rdata(rd[0]), .ro_err(roe[0]), .fill_req_valid(frv[0]), .fill_req_addr(fra[0]),
    .fill_rsp_valid(fv[0]), .fill_rsp_data(fd), .wb_valid(wbv[0]), .wb_addr(wba[0]), .wb_data(wbd[0]),
    .fwd_valid(fwv[0]), .fwd_addr(fwa[0]), .fwd_data(fwd[0]));
  cache_tagctl #(.REPL(1), .WPOL(2), .ALLOC_ON_FILL(1'b1)) dut_fifo (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_write(rw), .req_addr(ra), .req_wdata(rwd),
    .rsp_status(st[1]), .rsp_rdata(rd[1]), .ro_err(roe[1]), .fill_req_valid(frv[1]), .fill_req_addr(fra[1]),
    .fill_rsp_valid(fv[1]), .fill_rsp_data(fd), .wb_valid(wbv[1]), .wb_addr(wba[1]), .wb_data(wbd[1]),
    .fwd_valid(fwv[1]), .fwd_addr(fwa[1]), .fwd_data(fwd[1]));
  cache_tagctl #(.REPL(0), .WPOL(0), .ALLOC_ON_FILL(1'b1)) dut_ro (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[2]), .req_write(rw), .req_addr(ra), .req_wdata(rwd),
    .rsp_status(st[2]), .rsp_rdata(rd[2]), .ro_err(roe[2]), .fill_req_valid(frv[2]), .fill_req_addr(fra[2]),
    .fill_rsp_valid(fv[2]), .fill_rsp_data(fd), .wb_valid(wbv[2]), .wb_addr(wba[2]), .wb_data(wbd[2]),
    .fwd_valid(fwv[2]), .fwd_addr(fwa[2]), .fwd_data(fwd[2]));
  cache_tagctl #(.NSETS(0)) dut_byp (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[3]), .req_write(rw), .req_addr(ra), .req_wdata(rwd),
    .rsp_status(st[3]), .rsp_rdata(rd[3]), .ro_err(roe[3]), .fill_req_valid(frv[3]), .fill_req_addr(fra[3]),
    .fill_rsp_valid(fv[3]), .fill_rsp_data(fd), .wb_valid(wbv[3]), .wb_addr(wba[3]), .wb_data(wbd[3]),
    .fwd_valid(fwv[3]), .fwd_addr(fwa[3]), .fwd_data(fwd[3]));

  function automatic logic [AW-1:0] A(input int tg, input int ix, input int of);
    return {tg[11:0], ix[1:0], of[1:0]};
  endfunction

  function automatic logic [LB-1:0] ln(input logic [DW-1:0] b);
    return {b + 32'd3, b + 32'd2, b + 32'd1, b};
  endfunction

  task automatic chk(input string r, input logic [LB-1:0] got, input logic [LB-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", r, got, exp);
    end
  endtask

  task automatic put_req(input int i, input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    rv = '0; fv = '0; rv[i] = 1'b1; rw = wr; ra = a; rwd = d;
    #1;
  endtask

  task automatic put_fill(input int i, input logic [LB-1:0] d);
    @(negedge clk);
    rv = '0; fv = '0; fv[i] = 1'b1; fd = d;
    #1;
  endtask

  task automatic put_both(input int i, input logic [AW-1:0] a, input logic [LB-1:0] d);
    @(negedge clk);
    rv = '0; fv = '0; rv[i] = 1'b1; fv[i] = 1'b1; rw = 1'b0; ra = a; fd = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    rv = '0; fv = '0;
    #1;
  endtask

  task automatic t_reset();
    idle();
    for (int i = 0; i < 4; i++) begin
      chk("R3 reset no fill req", frv[i], 0);
      chk("R7 reset no writeback", wbv[i], 0);
      chk("R9 reset no forward", fwv[i], 0);
    end
  endtask

  task automatic t_miss_path();
    put_req(0, 0, A(1,0,1), 0);
    chk("R3 first miss status", st[0], 1);
    chk("R3 fill req raised", frv[0], 1);
    chk("R1 R3 fill line address", fra[0], A(1,0,0));
    put_req(0, 0, A(1,0,2), 0);
    chk("R3 same line pending", st[0], 2);
    chk("R3 no second fill", frv[0], 0);
    put_req(0, 0, A(2,0,0), 0);
    chk("R3 other line resfail", st[0], 3);
    put_both(0, A(3,1,0), ln(32'h100));
    chk("R11 request during fill", st[0], 3);
    chk("R11 no fill req during fill", frv[0], 0);
    put_req(0, 0, A(1,0,1), 0);
    chk("R2 read hit status", st[0], 0);
    chk("R2 read hit word", rd[0], 32'h101);
    put_req(0, 0, A(3,1,0), 0);
    chk("R11 blocked request left no state", st[0], 1);
    put_fill(0, ln(32'h300));
    idle();
  endtask

  task automatic t_lru_wb();
    put_req(0, 0, A(2,0,0), 0);
    put_fill(0, ln(32'h200));
    put_req(0, 0, A(1,0,0), 0);
    chk("R6 way0 hit before write", rd[0], 32'h100);
    put_req(0, 1, A(1,0,2), 32'hDEAD);
    chk("R7 write hit status", st[0], 0);
    chk("R7 write hit not forwarded", fwv[0], 0);
    put_req(0, 0, A(1,0,2), 0);
    chk("R7 written word readable", rd[0], 32'hDEAD);
    put_req(0, 0, A(3,0,0), 0);
    chk("R7 clean victim no writeback", wbv[0], 0);
    put_req(0, 0, A(2,0,1), 0);
    chk("R4 reserved victim stops hitting", st[0], 3);
    put_fill(0, ln(32'h500));
    put_req(0, 0, A(1,0,0), 0);
    chk("R6 LRU kept recently hit line", st[0], 0);
    put_req(0, 0, A(3,0,3), 0);
    chk("R4 fill into reserved way", rd[0], 32'h503);
    put_req(0, 0, A(4,0,0), 0);
    chk("R7 dirty victim writeback", wbv[0], 1);
    chk("R7 writeback address", wba[0], A(1,0,0));
    chk("R7 writeback data", wbd[0], {32'h103, 32'hDEAD, 32'h101, 32'h100});
    put_fill(0, ln(32'h700));
    put_req(0, 0, A(4,0,1), 0);
    chk("R1 offset selects word", rd[0], 32'h701);
    idle();
  endtask

  task automatic t_write_miss();
    put_req(0, 1, A(9,2,1), 32'h55);
    chk("R9 write miss status", st[0], 1);
    chk("R9 write miss forwarded", fwv[0], 1);
    chk("R9 forward address", fwa[0], A(9,2,1));
    chk("R9 forward data", fwd[0], 32'h55);
    chk("R9 write miss no fill", frv[0], 0);
    put_req(0, 0, A(9,2,1), 0);
    chk("R9 write miss not allocated", st[0], 1);
    put_req(0, 1, A(9,2,3), 32'h66);
    chk("R9 write to pending line", st[0], 3);
    chk("R9 pending write not forwarded", fwv[0], 0);
    put_fill(0, ln(32'h900));
    put_req(0, 0, A(9,2,3), 0);
    chk("R9 refused write left line", rd[0], 32'h903);
    idle();
  endtask

  task automatic t_fifo_wt();
    put_req(1, 0, A(1,1,0), 0);
    put_fill(1, ln(32'h100));
    put_req(1, 0, A(2,1,0), 0);
    put_fill(1, ln(32'h200));
    put_req(1, 0, A(1,1,0), 0);
    chk("R6 FIFO hit", st[1], 0);
    put_req(1, 1, A(1,1,0), 32'h77);
    chk("R8 write hit status", st[1], 0);
    chk("R8 write hit forwarded", fwv[1], 1);
    chk("R8 forwarded data", fwd[1], 32'h77);
    chk("R8 forwarded address", fwa[1], A(1,1,0));
    put_req(1, 0, A(1,1,0), 0);
    chk("R8 line updated", rd[1], 32'h77);
    put_req(1, 0, A(3,1,0), 0);
    chk("R5 miss issued", frv[1], 1);
    put_req(1, 0, A(1,1,1), 0);
    chk("R5 victim still hits before fill", rd[1], 32'h101);
    put_fill(1, ln(32'h300));
    chk("R8 no writeback on eviction", wbv[1], 0);
    put_req(1, 0, A(3,1,1), 0);
    chk("R5 fill installed", rd[1], 32'h301);
    put_req(1, 0, A(2,1,2), 0);
    chk("R6 FIFO kept younger install", rd[1], 32'h202);
    put_req(1, 0, A(1,1,0), 0);
    chk("R6 FIFO evicted oldest install", st[1], 1);
    put_fill(1, ln(32'h100));
    idle();
  endtask

  task automatic t_ro();
    put_req(2, 0, A(1,0,0), 0);
    put_fill(2, ln(32'h100));
    put_req(2, 1, A(1,0,1), 32'h88);
    chk("R10 write status", st[2], 3);
    chk("R10 error flag", roe[2], 1);
    chk("R10 nothing forwarded", fwv[2], 0);
    put_req(2, 0, A(1,0,1), 0);
    chk("R10 data unchanged", rd[2], 32'h101);
    chk("R10 flag only on writes", roe[2], 0);
    put_req(2, 1, A(5,3,0), 32'h1);
    chk("R10 write miss refused", roe[2], 1);
    chk("R10 write miss no fill", frv[2], 0);
    idle();
  endtask

  task automatic t_bypass();
    put_req(3, 0, A(1,0,2), 0);
    chk("R12 read status", st[3], 1);
    chk("R12 read sent on", frv[3], 1);
    chk("R12 read address", fra[3], A(1,0,2));
    put_req(3, 1, A(1,0,2), 32'h99);
    chk("R12 write forwarded", fwv[3], 1);
    chk("R12 write data", fwd[3], 32'h99);
    put_fill(3, ln(32'h100));
    put_req(3, 0, A(1,0,2), 0);
    chk("R12 nothing cached", st[3], 1);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_miss_path();
    t_lru_wb();
    t_write_miss();
    t_fifo_wt();
    t_ro();
    t_bypass();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule